// File: doc/BRIEF.md
# Ring Oscillator Frequency Comparator

This block reads out a ring-oscillator response. Two banks of free-running oscillator lines come in, each bank holding `2**SEL_W` lines that toggle with no relation to the system clock. One shared challenge word selects a single line from each bank. Both banks use identical 2:1 multiplexer trees driven by the same challenge bits. The two selected lines are brought into the clock domain, and their rising edges are counted over a fixed window of `WIN_CYC` clock cycles. When the window closes, the block registers a response bit. The bit is 1 only when the first bank's line produced strictly more edges than the second bank's line.

A measurement starts with a one-cycle `start_i` while the block is idle. For the whole window the block raises `osc_en_o`, which is the run enable for the oscillators. After the window, `done_o` pulses for one cycle and `resp_o` takes its new value. All pins are plain control and status signals. There is no stream data and no back-pressure: a start that arrives while the block is busy is dropped, not held.

Top module: `osc_race_judge`

## Requirements
- R1: The challenge value selects bank line index equal to that value, with challenge bit 0 as its least significant bit. Tree level i uses challenge bit i as the select of every multiplexer at that level. A select of 0 passes the lower-indexed entry of each adjacent pair, and a select of 1 passes the higher-indexed entry.
- R2: The same registered challenge steers both banks, so bank A line k and bank B line k are always compared against each other.
- R3: Each selected line passes through a two-flop synchronizer and a rising-edge detector. Its counter adds one per detected rising edge, only while the window is open. A line that does not toggle adds nothing.
- R4: At the end of a window, `resp_o` becomes 1 when the bank A count is strictly greater than the bank B count. It becomes 0 otherwise, and that includes equal counts.
- R5: A `start_i` seen at a clock edge while the block is idle clears both counters and opens the window. `osc_en_o` is high for exactly `WIN_CYC` cycles, beginning the cycle after that edge.
- R6: `done_o` is high for exactly one cycle, two cycles after `osc_en_o` falls, so that it is seen at the (`WIN_CYC`+2)th clock after the accepting edge. `resp_o` changes only at the edge that raises `done_o`.
- R7: Counters saturate at `2**CNT_W-1` and do not wrap. A line that would exceed that value still compares as the maximum.
- R8: The challenge is captured when a start is accepted. Challenge changes and extra `start_i` pulses during a measurement have no effect on its result or its timing.
- R9: After reset, `done_o`, `resp_o` and `osc_en_o` are 0.
- R10: A `start_i` in the same cycle that `done_o` is high is accepted and begins a new measurement at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a measurement; taken only while idle |
| chal_i | input | SEL_W | Challenge word selecting one line per bank |
| bank_a_i | input | 2**SEL_W | First oscillator bank, asynchronous lines |
| bank_b_i | input | 2**SEL_W | Second oscillator bank, asynchronous lines |
| osc_en_o | output | 1 | Oscillator run enable, high during the window |
| done_o | output | 1 | One-cycle pulse when the response is updated |
| resp_o | output | 1 | Registered comparison result |

## Verification
Two things can happen in the same cycle: the done pulse that publishes one result, and the acceptance of the next start. The bench provokes this by raising `start_i` in the very cycle where `done_o` is seen high, after swapping the oscillator speeds. It then judges that the oscillator enable comes back one cycle later for a full window, and that the second result reflects the swapped speeds. It also checks that the first result stays on `resp_o` until the second done pulse. A second overlap is a start pulse combined with a challenge change in the middle of a window. There the judge is that the done timing and the response both follow the first start's challenge.

// File: rtl/osc_race_pkg.sv
`timescale 1ns/1ps
package osc_race_pkg;
  // measurement phases of the comparator
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_CLOSE = 2'd2
  } phase_t;
endpackage

// File: rtl/osc_sel_tree.sv
`timescale 1ns/1ps
// Binary 2:1 multiplexer tree; level l uses sel_i[l] on adjacent pairs.
module osc_sel_tree #(
  parameter int SEL_W = 3
) (
  input  logic [(1<<SEL_W)-1:0] in_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  out_o
);
  localparam int NL = 1 << SEL_W;

  logic [NL-1:0] cur;
  logic [NL-1:0] nxt;

  always_comb begin
    cur = in_i;
    nxt = '0;
    for (int l = 0; l < SEL_W; l++) begin
      nxt = '0;
      for (int j = 0; j < (NL >> (l + 1)); j++) begin
        nxt[j] = sel_i[l] ? cur[2*j+1] : cur[2*j];
      end
      cur = nxt;
    end
    out_o = cur[0];
  end
endmodule

// File: rtl/osc_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a rising-edge detector.
module osc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;

  // R3: a rising edge yields a single pulse, never two in a row
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/osc_sat_counter.sv
`timescale 1ns/1ps
// Saturating event counter with synchronous clear.
module osc_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && (cnt_o != CMAX))  cnt_o <= cnt_o + 1'b1;
  end

  a_r7_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_o == CMAX) |=> (cnt_o == CMAX));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/osc_lane.sv
`timescale 1ns/1ps
// One bank: selection tree, synchronizer/edge detector, counter.
module osc_lane #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] lines_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  clr_i,
  input  logic                  cnt_en_i,
  output logic [CNT_W-1:0]      cnt_o
);
  logic picked;
  logic rise;

  osc_sel_tree #(.SEL_W(SEL_W)) u_tree (
    .in_i  (lines_i),
    .sel_i (sel_i),
    .out_o (picked)
  );

  osc_edge_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (picked),
    .rise_o (rise)
  );

  osc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .inc_i (rise & cnt_en_i),
    .cnt_o (cnt_o)
  );
endmodule

// File: rtl/osc_race_judge.sv
`timescale 1ns/1ps
module osc_race_judge #(
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 8,
  parameter int WIN_CYC = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [SEL_W-1:0]      chal_i,
  input  logic [(1<<SEL_W)-1:0] bank_a_i,
  input  logic [(1<<SEL_W)-1:0] bank_b_i,
  output logic                  osc_en_o,
  output logic                  done_o,
  output logic                  resp_o
);
  import osc_race_pkg::*;

  localparam int NL    = 1 << SEL_W;
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  phase_t           phase_q;
  logic [WIN_W-1:0] win_q;
  logic [SEL_W-1:0] chal_q;
  logic             done_q;
  logic             resp_q;

  logic             take_start;
  logic             counting;
  logic [NL-1:0]    banks [2];
  logic [CNT_W-1:0] cnts  [2];

  assign take_start = (phase_q == PH_IDLE) && start_i;
  assign counting   = (phase_q == PH_RUN);
  assign banks[0]   = bank_a_i;
  assign banks[1]   = bank_b_i;

  // identical lanes for both banks share the captured challenge
  for (genvar b = 0; b < 2; b++) begin : g_lane
    osc_lane #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_i  (banks[b]),
      .sel_i    (chal_q),
      .clr_i    (take_start),
      .cnt_en_i (counting),
      .cnt_o    (cnts[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      win_q   <= '0;
      chal_q  <= '0;
      done_q  <= 1'b0;
      resp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_RUN;
            win_q   <= '0;
            chal_q  <= chal_i;
          end
        end
        PH_RUN: begin
          if (win_q == WIN_LAST) phase_q <= PH_CLOSE;
          else                   win_q   <= win_q + 1'b1;
        end
        PH_CLOSE: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
          resp_q  <= (cnts[0] > cnts[1]);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign osc_en_o = counting;
  assign done_o   = done_q;
  assign resp_o   = resp_q;

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r6_done_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(phase_q) == PH_CLOSE));

  a_r6_resp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(resp_q));

  a_r8_chal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q != PH_IDLE) && ($past(phase_q) != PH_IDLE)) |-> $stable(chal_q));

  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (win_q <= WIN_LAST));
endmodule

// File: tb/osc_race_judge_bench.sv
`timescale 1ns/1ps
module osc_race_judge_bench;
  localparam int SEL_W = 3;
  localparam int CNT_W = 5;
  localparam int WIN   = 96;
  localparam int NL    = 1 << SEL_W;

  // half periods in ps
  localparam int H_FAST = 8500;
  localparam int H_QUICK = 13000;
  localparam int H_MED  = 20000;
  localparam int H_MID  = 26000;
  localparam int H_SLOW = 32000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SEL_W-1:0] chal = '0;
  logic [NL-1:0] bank_a, bank_b;
  logic osc_en, done, resp;

  int half_a [NL];
  int half_b [NL];
  logic oa [NL];
  logic ob [NL];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  osc_race_judge #(.SEL_W(SEL_W), .CNT_W(CNT_W), .WIN_CYC(WIN)) u_osc_race_judge (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chal_i(chal),
    .bank_a_i(bank_a), .bank_b_i(bank_b),
    .osc_en_o(osc_en), .done_o(done), .resp_o(resp)
  );

  for (genvar g = 0; g < NL; g++) begin : g_osc
    assign bank_a[g] = oa[g];
    assign bank_b[g] = ob[g];
    initial begin
      oa[g] = 1'b0;
      forever begin
        if (osc_en === 1'b1 && half_a[g] != 0) begin
          #(half_a[g] * 1ps);
          oa[g] = (osc_en === 1'b1) ? ~oa[g] : 1'b0;
        end else begin
          oa[g] = 1'b0;
          @(posedge osc_en);
        end
      end
    end
    initial begin
      ob[g] = 1'b0;
      forever begin
        if (osc_en === 1'b1 && half_b[g] != 0) begin
          #(half_b[g] * 1ps);
          ob[g] = (osc_en === 1'b1) ? ~ob[g] : 1'b0;
        end else begin
          ob[g] = 1'b0;
          @(posedge osc_en);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_a(input int k, input int hk, input int hrest);
    for (int i = 0; i < NL; i++) half_a[i] = (i == k) ? hk : hrest;
  endtask

  task automatic set_b(input int k, input int hk, input int hrest);
    for (int i = 0; i < NL; i++) half_b[i] = (i == k) ? hk : hrest;
  endtask

  // one measurement; checks result and, if asked, window and done timing
  task automatic run_meas(input int exp_resp, input string tag,
                          input bit timing, input bit disturb, input bit now);
    int n = 1;
    int en_cnt = 0;
    int done_at = -1;
    int moved = 0;
    logic prev;
    prev = resp;
    if (!now) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_at < 0 && n <= WIN + 20) begin
      if (n > 1) @(negedge clk);
      if (disturb && n == 10) begin
        chal  = ~chal;
        start = 1'b1;
      end
      if (disturb && n == 11) start = 1'b0;
      if (osc_en === 1'b1) en_cnt++;
      if (done === 1'b1) done_at = n;
      else if (resp !== prev) moved = 1;
      n++;
    end
    chk({tag, " response"}, int'(resp), exp_resp);
    if (timing) begin
      chk({tag, " R5 osc_en window length"}, en_cnt, WIN);
      chk({tag, " R6 done position"}, done_at, WIN + 2);
      chk({tag, " R6 response held until done"}, moved, 0);
    end
  endtask

  task automatic t_reset;
    chk("R9 done after reset", int'(done), 0);
    chk("R9 resp after reset", int'(resp), 0);
    chk("R9 osc_en after reset", int'(osc_en), 0);
  endtask

  task automatic t_basic;
    chal = 3'd0;
    set_a(0, H_MED, H_MED);
    set_b(0, H_SLOW, H_SLOW);
    run_meas(1, "R4 A faster", 1, 0, 0);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    chk("R5 osc_en low after window", int'(osc_en), 0);
    set_a(0, H_SLOW, H_SLOW);
    set_b(0, H_MED, H_MED);
    run_meas(0, "R4 B faster", 1, 0, 0);
  endtask

  task automatic t_select_a;
    set_a(5, H_MED, H_SLOW);
    set_b(0, H_MID, H_MID);
    for (int c = 0; c < NL; c++) begin
      chal = SEL_W'(c);
      run_meas((c == 5) ? 1 : 0, $sformatf("R1 bank A sweep chal=%0d", c), 0, 0, 0);
    end
  endtask

  task automatic t_select_b;
    set_a(0, H_MID, H_MID);
    set_b(2, H_MED, H_SLOW);
    for (int c = 0; c < NL; c++) begin
      chal = SEL_W'(c);
      run_meas((c == 2) ? 0 : 1, $sformatf("R2 bank B sweep chal=%0d", c), 0, 0, 0);
    end
  endtask

  task automatic t_stopped;
    chal = 3'd3;
    set_a(0, 0, 0);
    set_b(0, 0, 0);
    run_meas(0, "R4 both stopped equal", 0, 0, 0);
    set_a(0, H_SLOW, H_SLOW);
    run_meas(1, "R3 slow line beats stopped line", 0, 0, 0);
  endtask

  task automatic t_saturate;
    chal = 3'd1;
    set_a(0, H_FAST, H_FAST);
    set_b(0, H_QUICK, H_QUICK);
    run_meas(1, "R7 saturated A beats near-max B", 0, 0, 0);
    set_b(0, H_FAST, H_FAST);
    run_meas(0, "R7 both saturated equal", 0, 0, 0);
    set_a(0, H_SLOW, H_SLOW);
    set_b(0, H_MED, H_MED);
    run_meas(0, "R5 counters cleared after saturation", 0, 0, 0);
  endtask

  task automatic t_disturb;
    chal = 3'd0;
    set_a(0, H_MED, H_SLOW);
    set_b(0, H_MID, H_MID);
    run_meas(1, "R8 mid-run challenge and start ignored", 1, 1, 0);
  endtask

  task automatic t_back_to_back;
    chal = 3'd4;
    set_a(0, H_MED, H_MED);
    set_b(0, H_SLOW, H_SLOW);
    run_meas(1, "R10 first of pair", 0, 0, 0);
    set_a(0, H_SLOW, H_SLOW);
    set_b(0, H_MED, H_MED);
    run_meas(0, "R10 start on done cycle", 1, 0, 1);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      half_a[i] = 0;
      half_b[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_select_a();
    t_select_b();
    t_stopped();
    t_saturate();
    t_disturb();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule